// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block serialises host characters onto an asynchronous serial line. A one-character holding stage sits in front of a frame shifter. A character written while the shifter is idle goes straight to the shifter. A character written while a frame is on the line waits in the holding stage. It enters the shifter at the closing tick of the current stop bit, and its start bit follows with no idle gap.

Each bit lasts one period of an externally supplied single-cycle baud tick. The frame has an optional parity bit, with even or odd parity selected at the moment a character enters the shifter. The block has two status flags. The ready flag shows that the holding stage can take a character, and it also serves as the DMA write request. The empty flag shows that nothing is queued or on the line. A sticky overrun flag records writes that were lost. Dropping the enable aborts everything and parks the line high.

Top module: `serial_tx_dbuf`

## Requirements
- R1: On leaving reset with the enable high, the line is high, ready and empty are high and overrun is low.
- R2: While enabled, ready is high exactly when the holding stage is free, and the DMA request always equals ready.
- R3: A write accepted while the shifter is idle goes straight into the shifter, and ready stays high.
- R4: A write accepted while a frame is in progress fills the holding stage and drops ready. Ready rises again in the cycle after the held character enters the shifter.
- R5: The line idles high. After a load, the first baud tick begins a low start bit. The data bits follow least significant bit first, then a high stop bit. The line changes only on a baud tick or on disable.
- R6: The parity selector is 2 bits and is sampled when a character enters the shifter: 00 gives no parity bit, 01 even, 10 odd, 11 behaves as 00. The parity bit follows the last data bit.
- R7: Empty is high only when the holding stage is free and the shifter is idle. It rises in the cycle after the baud tick that closes the final stop bit.
- R8: A write while the holding stage is full is dropped and sets a sticky overrun flag. The overrun flag clears on the clear input, and a new overrun in the same cycle as a clear wins.
- R9: With the enable low, ready and empty are low, the frame in progress is aborted, the held character is discarded, the line is high and writes are ignored.
- R10: When a character is held at the closing tick of a stop bit, its start bit begins on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| parity_mode | input | 2 | 00 none, 01 even, 10 odd, 11 none |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | DATA_BITS | Character to send |
| ovr_clr | input | 1 | Clears the overrun flag |
| txd | output | 1 | Serial line |
| hold_ready | output | 1 | Holding stage free |
| tx_empty | output | 1 | Nothing queued or on the line |
| dma_req | output | 1 | DMA write request |
| overrun | output | 1 | Sticky lost-write flag |

## Verification
A holding flag stuck full or stuck free shows at the ready and DMA request ports in the cycle after the faulty write. It shows again at the next stop tick, as a missing or extra start bit. A wrong bit counter or shift order corrupts the line within one baud period of the faulty bit. A shifter state that fails to return to idle keeps empty low from the tick that should have closed the frame. The bench's reference model compares every output each cycle, so each of these faults is reported in the cycle it first reaches a port.

// File: rtl/utx_pkg.sv
// Shared types for the double-buffered serial transmitter.
// Assumes: nothing beyond IEEE 1800-2017.
package utx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } line_state_t;

    localparam logic [1:0] PAR_EVEN = 2'b01;
    localparam logic [1:0] PAR_ODD  = 2'b10;
endpackage

// File: rtl/utx_hold.sv
// Holding stage: one character that waits while the shifter is busy.
// It also sorts each write into direct-to-shifter, held, or overrun.
// Assumes: 'take' is raised by the shifter only while hold_full is high.
module utx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          shifter_idle,
    input  logic          take,
    output logic          hold_full,
    output logic [DW-1:0] hold_data,
    output logic          direct_load,
    output logic          overrun_evt
);
    logic to_hold;

    // Classify the current write against the pre-edge state.
    always_comb begin
        direct_load = tx_en && wr_en && !hold_full && shifter_idle;
        to_hold     = tx_en && wr_en && !hold_full && !shifter_idle;
        overrun_evt = tx_en && wr_en && hold_full;
    end

    // Track occupancy and contents of the holding stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full <= 1'b0;
            hold_data <= '0;
        end else if (!tx_en) begin
            hold_full <= 1'b0;
        end else if (take) begin
            hold_full <= 1'b0;
        end else if (to_hold) begin
            hold_full <= 1'b1;
            hold_data <= wr_data;
        end
    end

    // R8
    dropped_write_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && wr_en && hold_full) |=> $stable(hold_data));
endmodule

// File: rtl/utx_shifter.sv
// Frame shifter: sends start, data LSB first, optional parity, stop.
// Each bit advances on a baud tick. It reloads back to back from the holding stage.
// Assumes: baud_tick is a single-cycle pulse; parity is latched at load.
module utx_shifter
    import utx_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic          baud_tick,
    input  logic [1:0]    parity_mode,
    input  logic          hold_full,
    input  logic [DW-1:0] hold_data,
    input  logic          direct_load,
    input  logic [DW-1:0] wr_data,
    output logic          txd,
    output logic          shifter_idle,
    output logic          take
);
    localparam int CW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    line_state_t   state;
    logic [CW-1:0] bit_cnt;
    logic [DW-1:0] shreg;
    logic          par_en, par_bit;
    logic [DW-1:0] load_data;
    logic          load_par_en, load_par_bit;

    // Choose the character to load and precompute its parity settings.
    always_comb begin
        load_data    = hold_full ? hold_data : wr_data;
        load_par_en  = (parity_mode == PAR_EVEN) || (parity_mode == PAR_ODD);
        load_par_bit = (^load_data) ^ (parity_mode == PAR_ODD);
        shifter_idle = (state == ST_IDLE);
        take = tx_en && hold_full &&
               ((state == ST_IDLE) || (baud_tick && state == ST_STOP));
    end

    // Advance the frame sequence on baud ticks; abort when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            par_en  <= 1'b0;
            par_bit <= 1'b0;
        end else if (!tx_en) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (hold_full || direct_load) begin
                    shreg   <= load_data;
                    par_en  <= load_par_en;
                    par_bit <= load_par_bit;
                    state   <= ST_ARMED;
                end
                ST_ARMED: if (baud_tick) state <= ST_START;
                ST_START: if (baud_tick) begin
                    state   <= ST_DATA;
                    bit_cnt <= '0;
                end
                ST_DATA: if (baud_tick) begin
                    shreg <= shreg >> 1;
                    if (bit_cnt == LAST_BIT) state <= par_en ? ST_PAR : ST_STOP;
                    else bit_cnt <= bit_cnt + 1'b1;
                end
                ST_PAR: if (baud_tick) state <= ST_STOP;
                ST_STOP: if (baud_tick) begin
                    if (hold_full) begin
                        shreg   <= load_data;
                        par_en  <= load_par_en;
                        par_bit <= load_par_bit;
                        state   <= ST_START;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Drive the line level from the frame position.
    always_comb begin
        case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_PAR:   txd = par_bit;
            default:  txd = 1'b1;
        endcase
    end

    // R5
    line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !baud_tick) |=> $stable(txd));

    // R10
    back_to_back_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && baud_tick && state == ST_STOP && hold_full) |=> !txd);
endmodule

// File: rtl/utx_status.sv
// Status flags: ready/DMA request, empty, and sticky overrun.
// Assumes: hold_full and shifter_idle come from registered state.
module utx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_en,
    input  logic hold_full,
    input  logic shifter_idle,
    input  logic overrun_evt,
    input  logic ovr_clr,
    output logic hold_ready,
    output logic tx_empty,
    output logic dma_req,
    output logic overrun
);
    // Derive the level flags from the enable and storage occupancy.
    always_comb begin
        hold_ready = tx_en && !hold_full;
        tx_empty   = hold_ready && shifter_idle;
        dma_req    = hold_ready;
    end

    // Hold the overrun flag until cleared; a new event beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)           overrun <= 1'b0;
        else if (overrun_evt) overrun <= 1'b1;
        else if (ovr_clr)     overrun <= 1'b0;
    end

    // R8
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);
endmodule

// File: rtl/serial_tx_dbuf.sv
// Top level of the double-buffered serial transmitter.
// Connects the holding stage, frame shifter and status flags.
// Assumes: baud tick generated outside; synchronous active-low reset.
module serial_tx_dbuf #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_en,
    input  logic                 baud_tick,
    input  logic [1:0]           parity_mode,
    input  logic                 wr_en,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 ovr_clr,
    output logic                 txd,
    output logic                 hold_ready,
    output logic                 tx_empty,
    output logic                 dma_req,
    output logic                 overrun
);
    logic                 hold_full, shifter_idle, take, direct_load, overrun_evt;
    logic [DATA_BITS-1:0] hold_data;

    utx_hold #(.DW(DATA_BITS)) u_hold (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .wr_en(wr_en), .wr_data(wr_data),
        .shifter_idle(shifter_idle), .take(take), .hold_full(hold_full),
        .hold_data(hold_data), .direct_load(direct_load), .overrun_evt(overrun_evt)
    );

    utx_shifter #(.DW(DATA_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_tick(baud_tick),
        .parity_mode(parity_mode), .hold_full(hold_full), .hold_data(hold_data),
        .direct_load(direct_load), .wr_data(wr_data), .txd(txd),
        .shifter_idle(shifter_idle), .take(take)
    );

    utx_status u_stat (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .hold_full(hold_full),
        .shifter_idle(shifter_idle), .overrun_evt(overrun_evt), .ovr_clr(ovr_clr),
        .hold_ready(hold_ready), .tx_empty(tx_empty), .dma_req(dma_req),
        .overrun(overrun)
    );

    // R9
    disable_parks_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> txd);

    // R7
    empty_means_quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> (txd && !hold_full));
endmodule

// File: tb/serial_tx_dbuf_tb.sv
module serial_tx_dbuf_tb;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b1;
    logic       baud_tick = 1'b0;
    logic [1:0] parity_mode = 2'b00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ovr_clr = 1'b0;
    logic       txd, hold_ready, tx_empty, dma_req, overrun;

    int checks = 0;
    int errors = 0;
    int tick_period = 4;
    int tcnt = 0;

    // reference model state
    logic [7:0] m_hold[$];
    bit         m_bits[$];
    int         m_pos = 0;
    bit         m_armed = 0;
    bit         m_active = 0;
    bit         m_ovr = 0;

    serial_tx_dbuf u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_tick(baud_tick),
        .parity_mode(parity_mode), .wr_en(wr_en), .wr_data(wr_data),
        .ovr_clr(ovr_clr), .txd(txd), .hold_ready(hold_ready),
        .tx_empty(tx_empty), .dma_req(dma_req), .overrun(overrun)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Build the bit list of one frame from the requirements (R5, R6).
    task automatic build_frame(input logic [7:0] d);
        m_bits.delete();
        m_bits.push_back(1'b0);
        for (int i = 0; i < 8; i++) m_bits.push_back(d[i]);
        if (parity_mode == 2'b01) m_bits.push_back(^d);
        else if (parity_mode == 2'b10) m_bits.push_back(~^d);
        m_bits.push_back(1'b1);
        m_pos = 0;
    endtask

    // Reference model step at every rising edge.
    always @(posedge clk) begin
        bit busy, full_pre, last;
        busy = m_armed || m_active;
        full_pre = (m_hold.size() > 0);
        if (!rst_n) begin
            m_hold.delete(); m_armed = 0; m_active = 0; m_ovr = 0;
        end else begin
            if (tx_en && wr_en && full_pre) m_ovr = 1;
            else if (ovr_clr) m_ovr = 0;
            if (!tx_en) begin
                m_hold.delete(); m_armed = 0; m_active = 0;
            end else begin
                last = m_active && (m_pos == m_bits.size() - 1);
                if (!busy) begin
                    if (full_pre) begin build_frame(m_hold.pop_front()); m_armed = 1; end
                    else if (wr_en) begin build_frame(wr_data); m_armed = 1; end
                end else if (baud_tick) begin
                    if (m_armed) begin m_armed = 0; m_active = 1; m_pos = 0; end
                    else if (last) begin
                        if (full_pre) begin build_frame(m_hold.pop_front()); m_active = 1; end
                        else m_active = 0;
                    end else m_pos++;
                end
                if (wr_en && !full_pre && busy) m_hold.push_back(wr_data);
            end
        end
    end

    // Compare every output shortly after each edge.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            bit e_ready;
            e_ready = tx_en && (m_hold.size() == 0);
            chk("R5 R6 R10 txd", txd, m_active ? m_bits[m_pos] : 1'b1);
            chk("R2 R4 ready", hold_ready, e_ready);
            chk("R2 dma_req", dma_req, e_ready);
            chk("R7 empty", tx_empty, e_ready && !m_armed && !m_active);
            chk("R8 overrun", overrun, m_ovr);
        end
    end

    // Baud tick generator.
    initial begin
        forever begin
            @(negedge clk);
            if (tcnt >= tick_period - 1) begin baud_tick = 1'b1; tcnt = 0; end
            else begin baud_tick = 1'b0; tcnt++; end
        end
    end

    task automatic do_write(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 2000 && !tx_empty; i++) @(negedge clk);
        chk("R7 frame completes", tx_empty, 1);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd", txd, 1); chk("R1 ready", hold_ready, 1);
        chk("R1 empty", tx_empty, 1); chk("R1 overrun", overrun, 0);

        // R3 direct load, R4 second write is held
        do_write(8'hA5);
        chk("R3 ready stays high", hold_ready, 1);
        chk("R7 empty low while busy", tx_empty, 0);
        do_write(8'h3C);
        chk("R4 ready drops", hold_ready, 0);
        wait_empty();

        // R6 each parity mode
        for (int m = 0; m < 4; m++) begin
            parity_mode = 2'(m);
            do_write(8'h5B + 8'(m * 37));
            wait_empty();
        end
        parity_mode = 2'b01;

        // R8 overrun and clear
        do_write(8'h11); do_write(8'h22); do_write(8'h33);
        chk("R8 overrun set", overrun, 1);
        @(negedge clk); ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
        chk("R8 overrun cleared", overrun, 0);
        wait_empty();

        // R9 disable mid-frame
        do_write(8'hF0); do_write(8'h0F);
        repeat (13) @(negedge clk);
        tx_en = 1'b0;
        @(negedge clk);
        chk("R9 line high", txd, 1); chk("R9 ready low", hold_ready, 0);
        chk("R9 empty low", tx_empty, 0);
        do_write(8'h99);
        tx_en = 1'b1;
        @(negedge clk);
        chk("R9 held char discarded", tx_empty, 1);
        chk("R9 write ignored", overrun, 0);

        // R2 DMA-driven stream, R10 back to back, tick every cycle
        tick_period = 1;
        for (int n = 0; n < 8; ) begin
            @(negedge clk);
            if (dma_req) begin wr_en = 1'b1; wr_data = 8'(8'h81 + n * 29); n++; end
            else wr_en = 1'b0;
        end
        @(negedge clk); wr_en = 1'b0;
        chk("R2 no overrun under DMA", overrun, 0);
        wait_empty();

        // mixed random traffic
        tick_period = 3;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            wr_en = ($urandom % 6 == 0);
            wr_data = 8'($urandom);
            ovr_clr = ($urandom % 23 == 0);
            if ($urandom % 40 == 0) parity_mode = 2'($urandom);
            tx_en = ($urandom % 300 != 0);
            if (c % 1000 == 999) tick_period = tick_period + 2;
        end
        wr_en = 1'b0; ovr_clr = 1'b0; tx_en = 1'b1;
        wait_empty();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL R5 watchdog actual=timeout expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule